// File: doc/BRIEF.md
# Base Timer with Selectable Clear Sources

This block is a 16-bit up-counter that serves as the time base for a set of capture/compare channels. While its count enable is high it steps by one each clock. Software can pick up to three ways to force it back to zero: a match against a dedicated clear-value register, a match against the channel 0 compare value, or a rising edge on an external pin. A match-driven clear does not act at once. The counter first shows the matched value, then that value plus one, and only then returns to zero.

Each clear source has its own side effects. A natural wrap from all-ones to zero always raises the overflow request and the base-timer interrupt. A match-driven clear raises both only when the match value lies in an upper window. A channel 0 clear also pulses the channel 0 interrupt. A pin-driven clear raises nothing. All pulses last one clock and coincide with the clock on which the counter becomes zero. An error flag shows when both match-driven clears are enabled at once, which is a setting software must avoid.

Top module: `base_timer`

## Requirements
- R1: After reset the counter is 0x0000, the clear value, the compare value and the control word are zero, and every pulse output and the error flag are low.
- R2: While cnt_en is low and no pin clear occurs, the counter holds its value.
- R3: With no match clear pending, a count step from 0xFFFF gives 0x0000. On that clock ovf_req and bt_irq pulse high for exactly one cycle.
- R4: With control bit 0 set, a count step from the clear value m arms a clear. The counter then reads m, m+1, 0x0000, 0x0001 on successive count steps.
- R5: With control bit 1 set, the same sequence applies to the channel 0 compare value. ch0_irq pulses for one cycle on the clock the counter becomes 0x0000.
- R6: A match-driven clear pulses ovf_req and bt_irq only if m was in the window for the interrupt-select bit (control bit 3). With the bit at 0 the window is 0x7FFF..0xFFFE. With the bit at 1 the window is 0x7FFF..0xFFFE joined with 0xBFFF..0xFFFE. Outside the window neither pulses.
- R7: With control bit 2 set, a rising edge on ext_pin clears the counter on the third clock edge after the pin is first sampled high, whatever cnt_en is. This clear cancels any armed match clear and raises none of ovf_req, bt_irq or ch0_irq.
- R8: cfg_err is high whenever control bits 0 and 1 are both set.
- R9: A write (wr_en high) selects its target with wr_sel: 0 is the clear value, 1 is the channel 0 compare value, 2 is the control word (bits [3:0]). The write takes effect on the next clock.
- R10: With control bit 2 clear, activity on ext_pin has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 clear value, 1 channel 0 compare, 2 control |
| wr_data | input | 16 | Write data |
| ext_pin | input | 1 | Asynchronous external clear pin |
| count | output | 16 | Current counter value |
| ovf_req | output | 1 | Overflow request pulse |
| bt_irq | output | 1 | Base-timer interrupt pulse |
| ch0_irq | output | 1 | Channel 0 interrupt pulse from a compare clear |
| cfg_err | output | 1 | Both match clears enabled |

## Verification
A synchronized pin edge can arrive on the very clock on which an armed match clear would fire. The two then compete for the counter and for the interrupt pulses. The bench forces this overlap by watching the counter until it sits one below the channel 0 compare value and raising the pin at that moment. The pin clear then lands on the clock the compare clear wanted. The overlap is judged correct when the counter reads zero, ch0_irq stays low, and the following count step gives 0x0001. Random stimulus repeats such overlaps with small match values, and a cycle-level model in the bench judges each one.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    SEL_CLRVAL = 2'd0,
    SEL_CMP0   = 2'd1,
    SEL_CTL    = 2'd2,
    SEL_NONE   = 2'd3
  } bt_wsel_e;

  typedef struct packed {
    logic win_sel;
    logic pin_en;
    logic cmp_en;
    logic reg_en;
  } bt_ctl_t;

  localparam int unsigned CTL_BITS = $bits(bt_ctl_t);

endpackage

// File: rtl/bt_pin_sync.sv
module bt_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q[0] <= 1'b0;
    else        q[0] <= pin_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q[i-1];
    end
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs
  import bt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] clr_val,
  output logic [W-1:0] cmp0_val,
  output bt_ctl_t      ctl,
  output logic         both_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_val  <= '0;
      cmp0_val <= '0;
      ctl      <= '0;
    end else if (wr_en) begin
      case (bt_wsel_e'(wr_sel))
        SEL_CLRVAL: clr_val  <= wr_data;
        SEL_CMP0:   cmp0_val <= wr_data;
        SEL_CTL:    ctl      <= bt_ctl_t'(wr_data[CTL_BITS-1:0]);
        default:    ;
      endcase
    end
  end

  assign both_err = ctl.reg_en & ctl.cmp_en;
endmodule

// File: rtl/bt_count_core.sv
module bt_count_core
  import bt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         pin_clr,
  input  bt_ctl_t      ctl,
  input  logic [W-1:0] clr_val,
  input  logic [W-1:0] cmp0_val,
  output logic [W-1:0] count,
  output logic         ovf_q,
  output logic         irq_q,
  output logic         ch0_q,
  output logic         pend_o
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] WIN_LO   = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WIN_MID  = {2'b10, {(W-2){1'b1}}};
  localparam logic [W-1:0] WIN_HI   = ALL_ONES - 1'b1;

  function automatic logic in_window(input logic [W-1:0] m, input logic sel);
    logic lo_win;
    logic mid_win;
    lo_win  = (m >= WIN_LO)  && (m <= WIN_HI);
    mid_win = (m >= WIN_MID) && (m <= WIN_HI);
    return sel ? (lo_win || mid_win) : lo_win;
  endfunction

  logic         reg_hit, cmp_hit, any_hit;
  logic [W-1:0] hit_val;
  logic         pend, pend_ovf, pend_ch0;

  assign reg_hit = ctl.reg_en && (count == clr_val);
  assign cmp_hit = ctl.cmp_en && (count == cmp0_val);
  assign any_hit = reg_hit || cmp_hit;
  assign hit_val = reg_hit ? clr_val : cmp0_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      pend     <= 1'b0;
      pend_ovf <= 1'b0;
      pend_ch0 <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
      ch0_q    <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
      ch0_q <= 1'b0;
      if (pin_clr) begin
        count <= '0;
        pend  <= 1'b0;
      end else if (cnt_en) begin
        if (pend) begin
          count <= '0;
          ovf_q <= pend_ovf;
          irq_q <= pend_ovf;
          ch0_q <= pend_ch0;
        end else begin
          count <= count + 1'b1;
          if (count == ALL_ONES) begin
            ovf_q <= 1'b1;
            irq_q <= 1'b1;
          end
        end
        pend     <= any_hit;
        pend_ovf <= in_window(hit_val, ctl.win_sel);
        pend_ch0 <= cmp_hit;
      end
    end
  end

  assign pend_o = pend;
endmodule

// File: rtl/base_timer.sv
module base_timer
  import bt_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ext_pin,
  output logic [W-1:0] count,
  output logic         ovf_req,
  output logic         bt_irq,
  output logic         ch0_irq,
  output logic         cfg_err
);
  bt_ctl_t      ctl;
  logic [W-1:0] clr_val, cmp0_val;
  logic         pin_rise, ext_clr, pend;

  bt_cfg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_val(clr_val), .cmp0_val(cmp0_val),
    .ctl(ctl), .both_err(cfg_err)
  );

  bt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .rise_o(pin_rise)
  );

  assign ext_clr = pin_rise & ctl.pin_en;

  bt_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_clr(ext_clr),
    .ctl(ctl), .clr_val(clr_val), .cmp0_val(cmp0_val),
    .count(count), .ovf_q(ovf_req), .irq_q(bt_irq), .ch0_q(ch0_irq),
    .pend_o(pend)
  );
endmodule

// File: rtl/base_timer_chk.sv
module base_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic         ovf_req,
  input logic         bt_irq,
  input logic         ch0_irq,
  input logic         cfg_err,
  input logic         ext_clr,
  input logic         pend
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ext_clr) |=> $stable(count));

  p_ovf_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_req |-> (count == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ext_clr && !pend) |=> (count == $past(count) + 1'b1));

  p_armed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ext_clr && pend) |=> (count == '0));

  p_ch0_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_irq |-> (count == '0));

  p_pin_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |=> (count == '0) && !ovf_req && !bt_irq && !ch0_irq);

  p_both_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[1:0] == 2'b11) |=> cfg_err);
endmodule

bind base_timer base_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .count(count), .ovf_req(ovf_req),
  .bt_irq(bt_irq), .ch0_irq(ch0_irq), .cfg_err(cfg_err),
  .ext_clr(ext_clr), .pend(pend)
);

// File: tb/base_timer_tb.sv
`timescale 1ns/1ps
module base_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_en = 1'b0, d_we = 1'b0, d_pin = 1'b0;
  logic [1:0]  d_sel = 2'd0;
  logic [15:0] d_data = 16'h0;
  logic [15:0] count;
  logic        ovf_req, bt_irq, ch0_irq, cfg_err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  base_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(d_en), .wr_en(d_we), .wr_sel(d_sel),
    .wr_data(d_data), .ext_pin(d_pin), .count(count), .ovf_req(ovf_req),
    .bt_irq(bt_irq), .ch0_irq(ch0_irq), .cfg_err(cfg_err)
  );

  // reference state
  logic [15:0] m_cnt = 0, m_clr = 0, m_cmp = 0;
  logic [3:0]  m_ctl = 0;
  logic        m_arm = 0, m_arm_ovf = 0, m_arm_ch0 = 0;
  logic        m_ovf = 0, m_irq = 0, m_ch0 = 0;
  logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;

  function automatic logic win_ok(input logic [15:0] m, input logic sel);
    logic a, b;
    a = (m != 16'hFFFF) && (m[15] || m == 16'h7FFF);
    b = (m != 16'hFFFF) && (m[15:14] == 2'b11 || m == 16'hBFFF);
    return sel ? (a | b) : a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic hit_r, hit_c, pclr;
    hit_r = m_ctl[0] && (m_cnt == m_clr);
    hit_c = m_ctl[1] && (m_cnt == m_cmp);
    pclr  = m_s2 && !m_s3 && m_ctl[2];
    m_ovf = 0; m_irq = 0; m_ch0 = 0;
    if (pclr) begin
      m_cnt = 0; m_arm = 0;
    end else if (d_en) begin
      if (m_arm) begin
        m_cnt = 0; m_ovf = m_arm_ovf; m_irq = m_arm_ovf; m_ch0 = m_arm_ch0;
      end else begin
        if (m_cnt == 16'hFFFF) begin m_ovf = 1; m_irq = 1; end
        m_cnt = m_cnt + 16'd1;
      end
      m_arm     = hit_r | hit_c;
      m_arm_ovf = win_ok(hit_r ? m_clr : m_cmp, m_ctl[3]);
      m_arm_ch0 = hit_c;
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = d_pin;
    if (d_we) begin
      if (d_sel == 2'd0) m_clr = d_data;
      else if (d_sel == 2'd1) m_cmp = d_data;
      else if (d_sel == 2'd2) m_ctl = d_data[3:0];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R4 count", count, m_cnt);
    check("R3 ovf_req", ovf_req, m_ovf);
    check("R6 bt_irq", bt_irq, m_irq);
    check("R5 ch0_irq", ch0_irq, m_ch0);
    check("R8 cfg_err", cfg_err, m_ctl[0] & m_ctl[1]);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    d_we = 1; d_sel = s; d_data = v;
    tick();
    d_we = 0;
  endtask

  task automatic run_to(input logic [15:0] v);
    int guard = 0;
    d_en = 1;
    while (count !== v && guard < 70000) begin tick(); guard++; end
  endtask

  task automatic pin_clear();
    wr(2'd2, 16'h0004);
    d_pin = 1; tick(); tick(); tick();
    d_pin = 0; tick();
  endtask

  initial begin
    #2500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", count, 16'h0);
    check("R1 ovf", {ovf_req, bt_irq, ch0_irq}, 3'b000);
    check("R1 err", cfg_err, 1'b0);

    // R2: count a bit then hold
    d_en = 1; repeat (7) tick();
    d_en = 0; held = count; repeat (5) tick();
    check("R2 hold", count, held);

    // R9 / R4: clear value 20, small m out of window
    wr(2'd0, 16'd20); wr(2'd2, 16'h0001);
    check("R9 write next clock", cfg_err, 1'b0);
    run_to(16'd20);
    tick(); check("R4 m+1", count, 16'd21);
    tick(); check("R4 zero", count, 16'd0);
    check("R6 no ovf small m", ovf_req, 1'b0);
    tick(); check("R4 one", count, 16'd1);

    // R5: compare clear
    wr(2'd1, 16'd5); wr(2'd2, 16'h0002);
    run_to(16'd6);
    tick(); check("R5 zero", count, 16'd0);
    check("R5 ch0_irq", ch0_irq, 1'b1);
    tick(); check("R5 pulse one cycle", ch0_irq, 1'b0);

    // R8
    d_en = 0;
    wr(2'd2, 16'h0003); check("R8 both set", cfg_err, 1'b1);
    wr(2'd2, 16'h0000); check("R8 cleared", cfg_err, 1'b0);

    // R10: pin ignored when disabled
    d_en = 1; repeat (4) tick(); d_en = 0;
    held = count;
    d_pin = 1; repeat (4) tick(); d_pin = 0; repeat (2) tick();
    check("R10 pin ignored", count, held);

    // R7: pin clear with count enable low
    wr(2'd2, 16'h0004);
    d_pin = 1; tick(); tick(); tick();
    check("R7 pin clear", count, 16'd0);
    d_pin = 0; tick();

    // R7 overlap with armed compare clear
    wr(2'd1, 16'd12); wr(2'd2, 16'h0006);
    run_to(16'd11);
    d_pin = 1; tick(); tick(); tick();
    check("R7 overlap count", count, 16'd0);
    check("R7 overlap no ch0", ch0_irq, 1'b0);
    d_pin = 0; tick();
    check("R7 armed cancelled", count, 16'd1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      d_en = ($urandom % 10) < 8;
      if (($urandom % 20) == 0) begin
        logic [1:0] s;
        s = 2'($urandom % 3);
        if (s == 2'd2) wr(s, 16'($urandom % 16));
        else           wr(s, 16'($urandom % 48));
      end else begin
        if (($urandom % 10) == 0) d_pin = ~d_pin;
        tick();
      end
    end
    d_pin = 0; tick(); tick();

    // R3: natural wrap
    pin_clear();
    wr(2'd2, 16'h0000);
    run_to(16'hFFFF);
    tick();
    check("R3 wrap count", count, 16'h0);
    check("R3 ovf_req", ovf_req, 1'b1);
    check("R3 bt_irq", bt_irq, 1'b1);
    tick(); check("R3 one cycle", ovf_req, 1'b0);

    // R6: m = 0x7FFF in window (select 0)
    wr(2'd0, 16'h7FFF); wr(2'd2, 16'h0001);
    run_to(16'h8000);
    tick();
    check("R6 in-window clear", count, 16'h0);
    check("R6 ovf in window", ovf_req, 1'b1);
    check("R6 irq in window", bt_irq, 1'b1);

    // R6/R5: m = 0x7FFE out of window (select 1), compare source
    wr(2'd1, 16'h7FFE); wr(2'd2, 16'h000A);
    run_to(16'h7FFF);
    tick();
    check("R5 compare clear", count, 16'h0);
    check("R6 ovf outside window", ovf_req, 1'b0);
    check("R5 ch0 pulse", ch0_irq, 1'b1);
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule